// File: doc/BRIEF.md
# Sliced 40-bit Register File

This block holds the working registers of a DSP datapath: a bank of 40-bit words that the arithmetic units read as operands and that loads, immediates and transfers write back. Each word is split into three fields. The low field is bits 15:0, the high field is bits 31:16 and the extension field is bits 39:32. Callers can reach the whole word or any of these fields through a per-port view code.

There are two combinational read ports and one clocked write port. Every port carries its own 3-bit view code. A read view shapes the selected word onto a 40-bit bus: raw, sign-extended, or zero-extended. A write view picks a merge rule that decides which fields take new data, which take sign copies, which are cleared and which keep their old contents. Reads always return the contents held before the current clock edge, so a write in the same cycle is never forwarded to a read.

View codes are shared by all ports: 0 whole word, 1 32-bit view (bits 31:0), 2 24-bit view (bits 39:16), 3 high field, 4 low field, 5 extension field, 6 16-bit load into the whole word, 7 no view.

Top module: `slice_regfile`

## Requirements
- R1: After reset every register reads as 40'h0 through view 0.
- R2: A write with view 0 stores all 40 bits of wdata. A read with view 0 or view 6 returns the stored word unchanged.
- R3: A write with view 6 puts wdata[15:0] into bits 31:16, fills bits 39:32 with copies of wdata[15] and clears bits 15:0.
- R4: A write with view 1 puts wdata[31:0] into bits 31:0 and fills bits 39:32 with copies of wdata[31]. A read with view 1 returns bits 31:0 sign-extended from bit 31 to 40 bits.
- R5: A write with view 2 puts wdata[15:0] into bits 31:16, fills bits 39:32 with copies of wdata[15] and leaves bits 15:0 unchanged. A read with view 2 returns bits 39:16 in rdata[23:0], sign-extended from bit 39.
- R6: Writes with view 3, 4 or 5 change only the high field (from wdata[15:0]), the low field (from wdata[15:0]) or the extension field (from wdata[7:0]) respectively. The other bits of that register keep their values.
- R7: Reads with view 3, 4 or 5 return the high, low or extension field in the least significant bits with all upper bits zero.
- R8: A write with view 7 leaves the register unchanged. A read with view 7 returns 40'h0.
- R9: A write changes only the register addressed by waddr, and nothing changes while wen is low.
- R10: When a read and a write address the same register in one cycle, the read returns the value from before the write. The written value is visible from the next cycle. The two read ports are independent of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| wen | input | 1 | Write enable |
| waddr | input | 3 | Write register index |
| wview | input | 3 | Write view code |
| wdata | input | 40 | Write data, right-aligned for narrow views |
| raddr0 | input | 3 | Read port 0 register index |
| rview0 | input | 3 | Read port 0 view code |
| rdata0 | output | 40 | Read port 0 data |
| raddr1 | input | 3 | Read port 1 register index |
| rview1 | input | 3 | Read port 1 view code |
| rdata1 | output | 40 | Read port 1 data |

## Verification
Two functions can fall in the same cycle: a write that merges into a register, and a read of that same register through either port. The bench provokes this with directed cycles that aim both a write and a read at one index, and with random traffic where the read address is often forced equal to the write address. Each such read is judged against the model's contents from before the edge, and a read in the following cycle must show the merged value.

// File: rtl/slice_rf_pkg.sv
package slice_rf_pkg;
   typedef enum logic [2:0] {
      V_FULL = 3'd0,
      V_W32  = 3'd1,
      V_W24  = 3'd2,
      V_HI   = 3'd3,
      V_LO   = 3'd4,
      V_EXT  = 3'd5,
      V_LD16 = 3'd6,
      V_NONE = 3'd7
   } view_e;
endpackage

// File: rtl/slice_wr_merge.sv
module slice_wr_merge
   import slice_rf_pkg::*;
#(
   parameter int L_W = 16,
   parameter int H_W = 16,
   parameter int E_W = 8,
   localparam int REG_W = L_W + H_W + E_W,
   localparam int LH_W  = L_W + H_W
) (
   input  logic [REG_W-1:0] old_val,
   input  logic [2:0]       view,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] new_val,
   output logic             upd
);
   logic [H_W-1:0] hdat;
   logic [E_W-1:0] hsign;
   logic [E_W-1:0] wsign;

   assign hdat  = wdata[H_W-1:0];
   assign hsign = {E_W{wdata[H_W-1]}};
   assign wsign = {E_W{wdata[LH_W-1]}};
   assign upd   = (view_e'(view) != V_NONE);

   always_comb begin
      case (view_e'(view))
         V_FULL: new_val = wdata;
         V_W32:  new_val = {wsign, wdata[LH_W-1:0]};
         V_W24:  new_val = {hsign, hdat, old_val[L_W-1:0]};
         V_LD16: new_val = {hsign, hdat, {L_W{1'b0}}};
         V_HI:   new_val = {old_val[REG_W-1:LH_W], hdat, old_val[L_W-1:0]};
         V_LO:   new_val = {old_val[REG_W-1:L_W], wdata[L_W-1:0]};
         V_EXT:  new_val = {wdata[E_W-1:0], old_val[LH_W-1:0]};
         default: new_val = old_val;
      endcase
   end
endmodule

// File: rtl/slice_rd_view.sv
module slice_rd_view
   import slice_rf_pkg::*;
#(
   parameter int L_W = 16,
   parameter int H_W = 16,
   parameter int E_W = 8,
   localparam int REG_W = L_W + H_W + E_W,
   localparam int LH_W  = L_W + H_W
) (
   input  logic [REG_W-1:0] val,
   input  logic [2:0]       view,
   output logic [REG_W-1:0] rdata
);
   always_comb begin
      case (view_e'(view))
         V_FULL, V_LD16: rdata = val;
         V_W32:  rdata = {{E_W{val[LH_W-1]}}, val[LH_W-1:0]};
         V_W24:  rdata = {{L_W{val[REG_W-1]}}, val[REG_W-1:L_W]};
         V_HI:   rdata = {{(REG_W-H_W){1'b0}}, val[L_W +: H_W]};
         V_LO:   rdata = {{(REG_W-L_W){1'b0}}, val[L_W-1:0]};
         V_EXT:  rdata = {{(REG_W-E_W){1'b0}}, val[REG_W-1 -: E_W]};
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/slice_regfile.sv
module slice_regfile
   import slice_rf_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int L_W      = 16,
   parameter int H_W      = 16,
   parameter int E_W      = 8,
   localparam int REG_W   = L_W + H_W + E_W,
   localparam int AW      = $clog2(NUM_REGS),
   localparam int NRP     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wen,
   input  logic [AW-1:0]    waddr,
   input  logic [2:0]       wview,
   input  logic [REG_W-1:0] wdata,
   input  logic [AW-1:0]    raddr0,
   input  logic [2:0]       rview0,
   output logic [REG_W-1:0] rdata0,
   input  logic [AW-1:0]    raddr1,
   input  logic [2:0]       rview1,
   output logic [REG_W-1:0] rdata1
);
   if (NUM_REGS < 2 || (1 << AW) != NUM_REGS) begin : g_bad_depth
      $error("slice_regfile: NUM_REGS must be a power of two, at least 2");
   end
   if (H_W < 2 || L_W < H_W || E_W < 1 || E_W > H_W) begin : g_bad_fields
      $error("slice_regfile: field widths need L_W >= H_W >= E_W >= 1");
   end

   logic [REG_W-1:0] regs [NUM_REGS];
   logic [REG_W-1:0] merged;
   logic             upd;

   slice_wr_merge #(.L_W(L_W), .H_W(H_W), .E_W(E_W)) merge_i (
      .old_val (regs[waddr]),
      .view    (wview),
      .wdata   (wdata),
      .new_val (merged),
      .upd     (upd)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (wen && upd && (waddr == AW'(i)))
            regs[i] <= merged;
      end

      AST_ONLY_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
         !(wen && waddr == AW'(i)) |=> $stable(regs[i])); // R9
   end

   logic [AW-1:0]    rsel [NRP];
   logic [2:0]       rsv  [NRP];
   logic [REG_W-1:0] rout [NRP];

   assign rsel[0] = raddr0;
   assign rsel[1] = raddr1;
   assign rsv[0]  = rview0;
   assign rsv[1]  = rview1;
   assign rdata0  = rout[0];
   assign rdata1  = rout[1];

   for (genvar p = 0; p < NRP; p++) begin : g_rport
      slice_rd_view #(.L_W(L_W), .H_W(H_W), .E_W(E_W)) view_i (
         .val   (regs[rsel[p]]),
         .view  (rsv[p]),
         .rdata (rout[p])
      );

      AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
         (rsv[p] == V_EXT) |-> (rout[p][REG_W-1:E_W] == '0)); // R7
   end

   AST_LD16_CLEARS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && wview == V_LD16) |=> (regs[$past(waddr)][L_W-1:0] == '0)); // R3

   AST_LO_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && wview == V_LO) |=>
      (regs[$past(waddr)][REG_W-1:L_W] == $past(regs[waddr][REG_W-1:L_W]))); // R6

   AST_NONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && wview == V_NONE) |=> (regs[$past(waddr)] == $past(regs[waddr]))); // R8
endmodule

// File: tb/slice_regfile_tb_top.sv
`timescale 1ns/1ps
module slice_regfile_tb_top;
   localparam int NR = 8;
   localparam int W  = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wen = 1'b0;
   logic [2:0]    waddr = '0, wview = '0, raddr0 = '0, rview0 = '0, raddr1 = '0, rview1 = '0;
   logic [W-1:0]  wdata = '0;
   logic [W-1:0]  rdata0, rdata1;

   logic [W-1:0]  mdl [NR];
   int            n_run = 0;
   int            n_fail = 0;
   bit            done = 1'b0;

   always #10 clk = ~clk;

   slice_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .wen(wen), .waddr(waddr), .wview(wview), .wdata(wdata),
      .raddr0(raddr0), .rview0(rview0), .rdata0(rdata0),
      .raddr1(raddr1), .rview1(rview1), .rdata1(rdata1)
   );

   function automatic logic [W-1:0] m_merge(logic [W-1:0] o, logic [2:0] v, logic [W-1:0] d);
      logic [W-1:0] r;
      r = o;
      case (v)
         3'd0: r = d;
         3'd1: begin r[31:0] = d[31:0]; r[39:32] = {8{d[31]}}; end
         3'd2: begin r[31:16] = d[15:0]; r[39:32] = {8{d[15]}}; end
         3'd3: r[31:16] = d[15:0];
         3'd4: r[15:0] = d[15:0];
         3'd5: r[39:32] = d[7:0];
         3'd6: begin r[31:16] = d[15:0]; r[39:32] = {8{d[15]}}; r[15:0] = '0; end
         default: r = o;
      endcase
      return r;
   endfunction

   function automatic logic [W-1:0] m_view(logic [W-1:0] x, logic [2:0] v);
      case (v)
         3'd0, 3'd6: return x;
         3'd1: return {{8{x[31]}}, x[31:0]};
         3'd2: return {{16{x[39]}}, x[39:16]};
         3'd3: return {24'h0, x[31:16]};
         3'd4: return {24'h0, x[15:0]};
         3'd5: return {32'h0, x[39:32]};
         default: return '0;
      endcase
   endfunction

   function automatic string tagf(logic we, logic [2:0] wa, logic [2:0] ra, logic [2:0] rv);
      if (we && wa == ra) return "R10";
      case (rv)
         3'd0, 3'd6: return "R2";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd7: return "R8";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %010h expected %010h", tag, act, exp);
      end
   endtask

   task automatic cycle(logic we, logic [2:0] wa, logic [2:0] wv, logic [W-1:0] wd,
                        logic [2:0] a0, logic [2:0] v0, logic [2:0] a1, logic [2:0] v1,
                        string t0, string t1);
      @(negedge clk);
      wen = we; waddr = wa; wview = wv; wdata = wd;
      raddr0 = a0; rview0 = v0; raddr1 = a1; rview1 = v1;
      #2;
      chk(t0, rdata0, m_view(mdl[a0], v0));
      chk(t1, rdata1, m_view(mdl[a1], v1));
      @(posedge clk);
      if (we) mdl[wa] = m_merge(mdl[wa], wv, wd);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < NR; i++) mdl[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      for (int i = 0; i < NR; i++)
         cycle(1'b0, 3'd0, 3'd0, '0, 3'(i), 3'd0, 3'(NR-1-i), 3'd0, "R1", "R1");

      // R2: whole-word write and read
      cycle(1'b1, 3'd3, 3'd0, 40'hA5_1234_5678, 3'd0, 3'd0, 3'd1, 3'd0, "R2", "R2");
      cycle(1'b0, 3'd0, 3'd0, '0, 3'd3, 3'd0, 3'd3, 3'd6, "R2", "R2");
      chk("R2", rdata0, 40'hA5_1234_5678);

      // R3: 16-bit load into whole word
      cycle(1'b1, 3'd3, 3'd6, 40'h00_0000_8001, 3'd3, 3'd0, 3'd3, 3'd0, "R10", "R10");
      cycle(1'b0, 3'd0, 3'd0, '0, 3'd3, 3'd0, 3'd3, 3'd4, "R3", "R3");
      chk("R3", rdata0, 40'hFF_8001_0000);

      // R6: field-only writes
      cycle(1'b1, 3'd3, 3'd3, 40'hFF_FFFF_1111, 3'd3, 3'd0, 3'd0, 3'd0, "R10", "R6");
      cycle(1'b1, 3'd3, 3'd4, 40'hFF_FFFF_2222, 3'd3, 3'd0, 3'd0, 3'd0, "R6", "R6");
      cycle(1'b1, 3'd3, 3'd5, 40'hFF_FFFF_FF3C, 3'd3, 3'd0, 3'd0, 3'd0, "R6", "R6");
      cycle(1'b0, 3'd0, 3'd0, '0, 3'd3, 3'd0, 3'd3, 3'd5, "R6", "R7");
      chk("R6", rdata0, 40'h3C_1111_2222);
      chk("R7", rdata1, 40'h00_0000_003C);

      // R4: 32-bit view
      cycle(1'b1, 3'd5, 3'd1, 40'h00_8000_0001, 3'd5, 3'd1, 3'd5, 3'd0, "R10", "R10");
      cycle(1'b0, 3'd0, 3'd0, '0, 3'd5, 3'd0, 3'd5, 3'd1, "R4", "R4");
      chk("R4", rdata0, 40'hFF_8000_0001);

      // R5: 24-bit view keeps the low field
      cycle(1'b1, 3'd5, 3'd2, 40'h00_0000_7FFF, 3'd5, 3'd0, 3'd5, 3'd2, "R10", "R10");
      cycle(1'b0, 3'd0, 3'd0, '0, 3'd5, 3'd0, 3'd5, 3'd2, "R5", "R5");
      chk("R5", rdata0, 40'h00_7FFF_0001);
      chk("R5", rdata1, 40'h00_0000_7FFF);

      // R8: view 7 neither writes nor reads data
      cycle(1'b1, 3'd3, 3'd7, 40'h12_3456_789A, 3'd3, 3'd7, 3'd3, 3'd0, "R8", "R10");
      cycle(1'b0, 3'd0, 3'd0, '0, 3'd3, 3'd0, 3'd3, 3'd7, "R8", "R8");
      chk("R8", rdata0, 40'h3C_1111_2222);
      chk("R8", rdata1, 40'h0);

      // R10: same-cycle read sees old value, next cycle sees new
      cycle(1'b1, 3'd2, 3'd0, 40'h77_6655_4433, 3'd2, 3'd0, 3'd2, 3'd4, "R10", "R10");
      chk("R10", rdata0, 40'h0);
      cycle(1'b0, 3'd0, 3'd0, '0, 3'd2, 3'd0, 3'd2, 3'd3, "R10", "R10");
      chk("R10", rdata0, 40'h77_6655_4433);

      // random traffic
      for (int k = 0; k < 3000; k++) begin
         logic          we;
         logic [2:0]    wa, wv, a0, a1, v0, v1;
         logic [W-1:0]  wd;
         we = ($urandom % 4) != 0;
         wa = 3'($urandom); wv = 3'($urandom);
         wd = {8'($urandom), 32'($urandom)};
         a0 = 3'($urandom); a1 = 3'($urandom);
         v0 = 3'($urandom); v1 = 3'($urandom);
         if (($urandom % 3) == 0) a0 = wa;
         cycle(we, wa, wv, wd, a0, v0, a1, v1, tagf(we, wa, a0, v0), tagf(we, wa, a1, v1));
      end

      // R9: final sweep of every register
      for (int i = 0; i < NR; i++)
         cycle(1'b0, 3'd0, 3'd0, '0, 3'(i), 3'd0, 3'(i), 3'd0, "R9", "R9");

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule